// File: doc/BRIEF.md
# Sorted-Window Running Maximum Filter

This block produces a running maximum over a sliding window of 8-bit samples that arrive on a line, one per valid cycle. It keeps every sample currently inside the window in a bank of slots held in descending order. Each slot carries an age tag, so the sample that leaves the window can be found and removed. Because the list stays sorted, the window maximum always sits in slot 0 and is read out with no reduction tree.

The window length is chosen at run time, from 2 up to a build-time ceiling (`MAX_WIN`, default 13). It is taken from `win_k_i` only on a line-start pulse. That pulse also empties the window, so that a new line starts with no history. For every accepted sample the block returns one result: the maximum of that sample and the samples before it on the same line, up to the window length. This is the horizontal half of a separable 2-D max-pool.

Top module: `rank_max_filter`

## Requirements
- R1: For each accepted sample, `out_data_o` equals the maximum of the last k accepted samples of the current line, including that sample. Fewer samples are used when the line holds fewer than k so far.
- R2: `out_valid_o` is high for exactly one cycle per accepted sample. It rises two rising clock edges after the edge that accepts the sample, and results come out in input order.
- R3: The window length is taken from `win_k_i` (unsigned) and clamped. A value below 2 gives 2, and a value above `MAX_WIN` gives `MAX_WIN`.
- R4: `win_k_i` is sampled only in a cycle where `line_start_i` is high. At any other time its value has no effect on results.
- R5: A cycle with `line_start_i` high empties the window, whether `in_valid_i` is high or not. A sample accepted in that same cycle is the first sample of the new line.
- R6: After reset, `out_valid_o` is low, the window is empty and the window length is `MAX_WIN` until the first line start.
- R7: Samples with equal values are each kept and aged separately. The maximum stays at that value as long as any copy is still inside the window.
- R8: Occupied slots are contiguous from slot 0, are in non-increasing order of value, and number no more than the current window length.
- R9: A cycle with `in_valid_i` low produces no result and does not change the window, whatever is on `in_data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Empties the window and captures the window length |
| win_k_i | input | 4 | Requested window length (clog2(MAX_WIN+1) bits) |
| in_valid_i | input | 1 | Sample on `in_data_i` is accepted |
| in_data_i | input | 8 | Unsigned input sample |
| out_valid_o | output | 1 | Result on `out_data_o` is valid |
| out_data_o | output | 8 | Window maximum |

## Verification
The assertions take for granted that `in_data_i` is unsigned. They also assume that at most one sample is accepted per cycle, so ages inside the window are distinct and at most one slot can expire on any sample. They further assume that `win_k_i` matters only alongside `line_start_i`, so the window never has to shrink in the middle of a line. The directed tests keep to these limits. They change `win_k_i` freely between line starts, drive random garbage on `in_data_i` whenever `in_valid_i` is low, and include lengths outside 2..`MAX_WIN` to exercise the clamp.

// File: rtl/rank_max_pkg.sv
package rank_max_pkg;
  typedef enum logic [1:0] {
    SEL_HOLD = 2'd0,
    SEL_NEW  = 2'd1,
    SEL_UP   = 2'd2,
    SEL_DOWN = 2'd3
  } slot_sel_e;
endpackage

// File: rtl/rm_cmp_slice.sv
module rm_cmp_slice #(
  parameter int DATA_W = 8,
  parameter int AGE_W  = 4
) (
  input  logic [DATA_W-1:0] smp_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              vld_i,
  input  logic              clr_i,
  input  logic [AGE_W-1:0]  age_i,
  input  logic [AGE_W-1:0]  last_age_i,
  output logic              gt_o,
  output logic              evict_o
);
  logic live;
  assign live    = vld_i & ~clr_i;
  // empty slots rank below any sample; ties keep the older entry above
  assign gt_o    = ~live | (smp_i > val_i);
  assign evict_o = live & (age_i == last_age_i);
endmodule

// File: rtl/rm_sel_ctrl.sv
module rm_sel_ctrl
  import rank_max_pkg::*;
#(
  parameter int NUM_SLOTS = 13
) (
  input  logic [NUM_SLOTS-1:0]            gt_i,
  input  logic [NUM_SLOTS-1:0]            evict_i,
  output slot_sel_e [NUM_SLOTS-1:0]       sel_o
);
  logic [NUM_SLOTS-1:0] ev_or;
  logic [NUM_SLOTS-1:0] gt_above;
  logic [NUM_SLOTS-1:0] gt_below;
  logic [NUM_SLOTS-1:0] ev_above;
  logic                 evict_high;

  always_comb begin
    logic run;
    run = 1'b0;
    for (int v = 0; v < NUM_SLOTS; v++) begin
      run      = run | evict_i[v];
      ev_or[v] = run;
    end
  end

  assign gt_above   = {gt_i[NUM_SLOTS-2:0], 1'b0};
  assign gt_below   = {1'b1, gt_i[NUM_SLOTS-1:1]};
  assign ev_above   = {ev_or[NUM_SLOTS-2:0], 1'b0};
  // expiring entry sits above the insertion point
  assign evict_high = |(evict_i & ~gt_i);

  always_comb begin
    for (int v = 0; v < NUM_SLOTS; v++) begin
      sel_o[v] = SEL_HOLD;
      if (!evict_high) begin
        if (gt_i[v] && !gt_above[v])        sel_o[v] = SEL_NEW;
        else if (gt_above[v] && !ev_above[v]) sel_o[v] = SEL_UP;
      end else begin
        if (!gt_i[v] && gt_below[v])        sel_o[v] = SEL_NEW;
        else if (ev_or[v] && !gt_below[v])  sel_o[v] = SEL_DOWN;
      end
    end
  end
endmodule

// File: rtl/rm_slot.sv
module rm_slot
  import rank_max_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int AGE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              clr_i,
  input  slot_sel_e         sel_i,
  input  logic [DATA_W-1:0] new_val_i,
  input  logic [DATA_W-1:0] up_val_i,
  input  logic [AGE_W-1:0]  up_age_i,
  input  logic              up_vld_i,
  input  logic [DATA_W-1:0] dn_val_i,
  input  logic [AGE_W-1:0]  dn_age_i,
  input  logic              dn_vld_i,
  output logic [DATA_W-1:0] val_o,
  output logic [AGE_W-1:0]  age_o,
  output logic              vld_o
);
  localparam logic [AGE_W-1:0] AGE_SAT = {AGE_W{1'b1}};

  function automatic logic [AGE_W-1:0] age_inc(input logic [AGE_W-1:0] a);
    return (a == AGE_SAT) ? a : a + 1'b1;
  endfunction

  logic [DATA_W-1:0] nxt_val;
  logic [AGE_W-1:0]  nxt_age;
  logic              nxt_vld;

  always_comb begin
    nxt_val = val_o;
    nxt_age = age_inc(age_o);
    nxt_vld = vld_o & ~clr_i;
    unique case (sel_i)
      SEL_NEW: begin
        nxt_val = new_val_i;
        nxt_age = '0;
        nxt_vld = 1'b1;
      end
      SEL_UP: begin
        nxt_val = up_val_i;
        nxt_age = age_inc(up_age_i);
        nxt_vld = up_vld_i & ~clr_i;
      end
      SEL_DOWN: begin
        nxt_val = dn_val_i;
        nxt_age = age_inc(dn_age_i);
        nxt_vld = dn_vld_i & ~clr_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o <= '0;
      age_o <= AGE_SAT;
      vld_o <= 1'b0;
    end else if (step_i) begin
      val_o <= nxt_val;
      age_o <= nxt_vld ? nxt_age : AGE_SAT;
      vld_o <= nxt_vld;
    end else if (clr_i) begin
      age_o <= AGE_SAT;
      vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rank_max_filter.sv
module rank_max_filter
  import rank_max_pkg::*;
#(
  parameter  int DATA_W  = 8,
  parameter  int MAX_WIN = 13,
  localparam int KW      = $clog2(MAX_WIN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_start_i,
  input  logic [KW-1:0]     win_k_i,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int NS = MAX_WIN;

  logic [KW-1:0]     kin_clamp, kin_q, k_q, k_eff, last_age;
  logic [DATA_W-1:0] smp_q;
  logic              vld_q, sol_q;

  logic [NS-1:0][DATA_W-1:0] slot_val;
  logic [NS-1:0][KW-1:0]     slot_age;
  logic [NS-1:0]             slot_vld;
  logic [NS-1:0]             gt, evict;
  slot_sel_e [NS-1:0]        sel;

  always_comb begin
    if (win_k_i < KW'(2))            kin_clamp = KW'(2);
    else if (win_k_i > KW'(MAX_WIN)) kin_clamp = KW'(MAX_WIN);
    else                             kin_clamp = win_k_i;
  end

  // input stage: comparator operands registered
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      sol_q <= 1'b0;
      smp_q <= '0;
      kin_q <= KW'(MAX_WIN);
    end else begin
      vld_q <= in_valid_i;
      sol_q <= line_start_i;
      if (in_valid_i)   smp_q <= in_data_i;
      if (line_start_i) kin_q <= kin_clamp;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q         <= KW'(MAX_WIN);
      out_valid_o <= 1'b0;
    end else begin
      if (sol_q) k_q <= kin_q;
      out_valid_o <= vld_q;
    end
  end

  assign k_eff    = sol_q ? kin_q : k_q;
  assign last_age = k_eff - 1'b1;

  for (genvar v = 0; v < NS; v++) begin : g_cmp
    rm_cmp_slice #(.DATA_W(DATA_W), .AGE_W(KW)) u_cmp (
      .smp_i     (smp_q),
      .val_i     (slot_val[v]),
      .vld_i     (slot_vld[v]),
      .clr_i     (sol_q),
      .age_i     (slot_age[v]),
      .last_age_i(last_age),
      .gt_o      (gt[v]),
      .evict_o   (evict[v])
    );
  end

  rm_sel_ctrl #(.NUM_SLOTS(NS)) u_sel (
    .gt_i   (gt),
    .evict_i(evict),
    .sel_o  (sel)
  );

  for (genvar v = 0; v < NS; v++) begin : g_slot
    logic [DATA_W-1:0] up_val, dn_val;
    logic [KW-1:0]     up_age, dn_age;
    logic              up_vld, dn_vld;

    if (v == 0) begin : g_top
      assign up_val = '0;
      assign up_age = '1;
      assign up_vld = 1'b0;
    end else begin : g_mid_up
      assign up_val = slot_val[v-1];
      assign up_age = slot_age[v-1];
      assign up_vld = slot_vld[v-1];
    end

    if (v == NS - 1) begin : g_bot
      assign dn_val = '0;
      assign dn_age = '1;
      assign dn_vld = 1'b0;
    end else begin : g_mid_dn
      assign dn_val = slot_val[v+1];
      assign dn_age = slot_age[v+1];
      assign dn_vld = slot_vld[v+1];
    end

    rm_slot #(.DATA_W(DATA_W), .AGE_W(KW)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (vld_q),
      .clr_i    (sol_q),
      .sel_i    (sel[v]),
      .new_val_i(smp_q),
      .up_val_i (up_val),
      .up_age_i (up_age),
      .up_vld_i (up_vld),
      .dn_val_i (dn_val),
      .dn_age_i (dn_age),
      .dn_vld_i (dn_vld),
      .val_o    (slot_val[v]),
      .age_o    (slot_age[v]),
      .vld_o    (slot_vld[v])
    );
  end

  assign out_data_o = slot_val[0];
endmodule

// File: rtl/rank_max_chk.sv
module rank_max_chk #(
  parameter  int DATA_W  = 8,
  parameter  int MAX_WIN = 13,
  localparam int KW      = $clog2(MAX_WIN + 1)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            in_valid_i,
  input logic [DATA_W-1:0]               in_data_i,
  input logic                            out_valid_o,
  input logic [DATA_W-1:0]               out_data_o,
  input logic [MAX_WIN-1:0]              slot_vld_i,
  input logic [MAX_WIN-1:0][DATA_W-1:0]  slot_val_i,
  input logic [MAX_WIN-1:0]              evict_i,
  input logic [KW-1:0]                   k_q_i,
  input logic                            sol_q_i
);
  p_lat_hi_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> ##1 out_valid_o);

  p_lat_lo_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ##1 !out_valid_o);

  p_out_ge_in_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_data_o >= $past(in_data_i, 2));

  p_one_expiry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(evict_i));

  p_k_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_q_i >= KW'(2)) && (k_q_i <= KW'(MAX_WIN)));

  p_k_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sol_q_i |=> $stable(k_q_i));

  p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_q_i |=> ($countones(slot_vld_i) <= 1));

  p_occupancy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(slot_vld_i) <= int'(k_q_i));

  for (genvar v = 0; v < MAX_WIN - 1; v++) begin : g_order
    p_sorted_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_vld_i[v+1] |-> (slot_vld_i[v] && (slot_val_i[v] >= slot_val_i[v+1])));
  end
endmodule

bind rank_max_filter rank_max_chk #(.DATA_W(DATA_W), .MAX_WIN(MAX_WIN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_data_i  (in_data_i),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .slot_vld_i (slot_vld),
  .slot_val_i (slot_val),
  .evict_i    (evict),
  .k_q_i      (k_q),
  .sol_q_i    (sol_q)
);

// File: tb/sim_rank_max_filter.sv
module sim_rank_max_filter;
  localparam int DATA_W  = 8;
  localparam int MAX_WIN = 13;
  localparam int KW      = $clog2(MAX_WIN + 1);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              line_start_i = 1'b0;
  logic [KW-1:0]     win_k_i = '0;
  logic              in_valid_i = 1'b0;
  logic [DATA_W-1:0] in_data_i = '0;
  logic              out_valid_o;
  logic [DATA_W-1:0] out_data_o;

  always #10 clk_i = ~clk_i;

  rank_max_filter #(.DATA_W(DATA_W), .MAX_WIN(MAX_WIN)) u0 (.*);

  int    n_chk = 0;
  int    n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  int    hist[$];
  int    bk = MAX_WIN;
  bit    finished = 0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  always @(negedge clk_i) begin
    int e;
    string t;
    if (rst_ni && out_valid_o && !finished) begin
      if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected result", 1, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(out_data_o) == e, t, "window max", int'(out_data_o), e);
      end
    end
  end

  task automatic drive(bit v, int x, bit sol, int kin, string tag);
    int m;
    in_valid_i   = v;
    in_data_i    = DATA_W'(x);
    line_start_i = sol;
    win_k_i      = KW'(kin);
    if (sol) begin
      hist.delete();
      bk = (kin < 2) ? 2 : ((kin > MAX_WIN) ? MAX_WIN : kin);
    end
    if (v) begin
      hist.push_back(x);
      m = 0;
      for (int i = 0; i < bk && i < hist.size(); i++)
        if (hist[hist.size()-1-i] > m) m = hist[hist.size()-1-i];
      exp_q.push_back(m);
      tag_q.push_back(tag);
    end
    @(negedge clk_i);
    in_valid_i   = 1'b0;
    line_start_i = 1'b0;
    in_data_i    = DATA_W'($urandom);
    win_k_i      = KW'($urandom);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R6", "valid in reset", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R6", "valid after reset", int'(out_valid_o), 0);
  endtask

  // no line start yet: window is MAX_WIN long
  task automatic t_default_len();
    drive(1, 200, 0, 2, "R6");
    for (int i = 0; i < 16; i++) drive(1, 10 + i, 0, 3, "R6");
    settle();
  endtask

  task automatic t_latency();
    drive(1, 77, 1, 4, "R2");
    chk(out_valid_o == 1'b0, "R2", "valid one edge after", int'(out_valid_o), 0);
    @(negedge clk_i);
    chk(out_valid_o == 1'b1, "R2", "valid two edges after", int'(out_valid_o), 1);
    @(negedge clk_i);
    chk(out_valid_o == 1'b0, "R2", "single-cycle valid", int'(out_valid_o), 0);
    settle();
  endtask

  task automatic t_ramps();
    drive(1, 0, 1, 5, "R1");
    for (int i = 1; i < 20; i++) drive(1, i * 12, 0, 5, "R1");
    for (int i = 19; i >= 0; i--) drive(1, i * 12, 0, 5, "R1");
    drive(1, 255, 0, 5, "R1");
    for (int i = 0; i < 7; i++) drive(1, 0, 0, 5, "R1");
    settle();
  endtask

  task automatic t_ties();
    int seq[14] = '{9, 9, 4, 9, 4, 4, 4, 9, 9, 9, 2, 2, 2, 0};
    drive(1, seq[0], 1, 3, "R7");
    for (int i = 1; i < 14; i++) drive(1, seq[i], 0, 3, "R7");
    settle();
  endtask

  task automatic t_clamp();
    drive(1, 100, 1, 0, "R3");
    for (int i = 0; i < 5; i++) drive(1, 90 - i * 10, 0, 9, "R3");
    drive(1, 100, 1, 1, "R3");
    for (int i = 0; i < 4; i++) drive(1, 50 - i, 0, 9, "R3");
    drive(1, 250, 1, 15, "R3");
    for (int i = 0; i < 18; i++) drive(1, 240 - i * 5, 0, 2, "R3");
    settle();
  endtask

  task automatic t_len_midline();
    drive(1, 200, 1, 4, "R4");
    for (int i = 0; i < 10; i++) drive(1, 190 - i * 10, 0, (i % 2) ? 2 : 12, "R4");
    settle();
  endtask

  task automatic t_line_clear();
    drive(1, 250, 1, 6, "R5");
    for (int i = 0; i < 4; i++) drive(1, 240, 0, 6, "R5");
    drive(1, 5, 1, 6, "R5");
    for (int i = 0; i < 4; i++) drive(1, 3 + i, 0, 6, "R5");
    drive(1, 222, 0, 6, "R5");
    drive(0, 0, 1, 3, "R5");
    for (int i = 0; i < 5; i++) drive(1, 8 - i, 0, 3, "R5");
    settle();
  endtask

  task automatic t_gaps();
    drive(1, 60, 1, 4, "R9");
    for (int i = 0; i < 12; i++) begin
      drive(0, 255, 0, 13, "R9");
      drive(0, 255, 0, 2, "R9");
      drive(1, 50 - i * 3, 0, 4, "R9");
    end
    settle();
    chk(exp_q.size() == 0, "R9", "pending results after gaps", exp_q.size(), 0);
  endtask

  task automatic t_random();
    for (int l = 0; l < 40; l++) begin
      int kin = $urandom_range(0, 15);
      int len = $urandom_range(1, 40);
      drive(1, $urandom_range(0, 255), 1, kin, "R1");
      for (int i = 1; i < len; i++) begin
        if ($urandom_range(0, 3) == 0) drive(0, 0, 0, 0, "R1");
        drive(1, ($urandom_range(0, 1) == 1) ? $urandom_range(0, 255) : $urandom_range(0, 3), 0,
              $urandom_range(0, 15), "R1");
      end
    end
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_default_len();
    t_latency();
    t_ramps();
    t_ties();
    t_clamp();
    t_len_midline();
    t_line_clear();
    t_gaps();
    t_random();
    settle();
    chk(exp_q.size() == 0, "R2", "results missing at end", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule